// File: doc/BRIEF.md
# Rising-Edge Phase Detector and Digital Aligner

This block closes a phase-alignment loop between two divided clocks of equal frequency: one from the controller side and one from the memory side. Both arrive as plain signals that are synchronised into a fast sampling clock. The block then compares only their rising edges. Each comparison moves a saturating phase code by one step, and that code selects the delay tap for the output clock. Over successive comparisons the loop drives the memory-side rising edge onto the controller-side rising edge. The start-up error may be as large as half an input period.

A comparison is counted as good when the rising-edge separation is no more than a small window of sample cycles. A lock flag rises after a run of good comparisons and drops on the first bad one. The loop freezes in three cases: when either input stops toggling (for example because it is tied low), when the aligner is bypassed, and when it is disabled. While frozen the code keeps its value, no step is issued and lock is reported as lost.

Top module: `phaseAligner`

## Requirements
- R1: After reset, phaseCode equals CODE_INIT (default 32 with CODE_W = 6), stepUp and stepDown are 0 and locked is 0.
- R2: Only rising edges are compared. The position of falling edges, and so the duty cycle of either input, has no effect on the direction, the code or the lock result.
- R3: If the controller-side rising edge is seen first, stepDown pulses for one cycle and phaseCode drops by one. If the memory-side rising edge is seen first, stepUp pulses and phaseCode rises by one. Both changes appear on the third sampling-clock rising edge after the later input edge is applied.
- R4: Rising edges that land in the same sample cycle give a zero-error comparison. It issues no step and counts as inside the window.
- R5: phaseCode saturates: a step up at 2^CODE_W-1 and a step down at 0 leave it unchanged, with no wrap.
- R6: locked goes to 1 at the comparison that completes LOCK_COUNT (default 4) consecutive comparisons whose separation is at most WINDOW (default 1) sample cycles.
- R7: locked goes to 0 at the first comparison whose separation exceeds WINDOW.
- R8: If either input shows no rising edge for IDLE_LIMIT (default 64) sample cycles, the code is held, no step is issued and locked is 0. The loop resumes on a pair of rising edges that land in the same sample cycle.
- R9: While bypass is 1 or enable is 0, no step is issued, phaseCode is held and locked is 0.
- R10: stepUp and stepDown are never high together, and phaseCode changes only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Loop enable |
| bypass | input | 1 | Aligner skipped (bypass or test mode); loop frozen |
| ctrlClkIn | input | 1 | Controller-side divided clock, asynchronous |
| memClkIn | input | 1 | Memory-side divided clock, asynchronous |
| phaseCode | output | CODE_W | Delay tap selection code |
| stepUp | output | 1 | One-cycle pulse: code stepped up |
| stepDown | output | 1 | One-cycle pulse: code stepped down |
| locked | output | 1 | Residual error inside the window for enough comparisons |

## Verification
A rising edge applied to an input is captured on the first sampling edge and is seen as a rise after the second. The comparison it completes updates phaseCode, the step pulse and the lock flag together on the third sampling edge. The bench applies all input changes on falling clock edges, and its monitor looks at the outputs on every falling edge. Each step pulse is therefore seen exactly once, and the monitor pairs it with the next queued expectation. The lock and hold checks are made only at the end of a full 16-cycle input period, well after the latest edge of the pair.

// File: rtl/phaseAlignPkg.sv
package phaseAlignPkg;

  typedef struct packed {
    logic ctrlRise;
    logic memRise;
  } edgePair_t;

  typedef struct packed {
    logic up;
    logic down;
  } stepCmd_t;

  typedef enum logic [1:0] {
    PAIR_IDLE      = 2'd0,
    PAIR_WAIT_MEM  = 2'd1,
    PAIR_WAIT_CTRL = 2'd2
  } pairState_e;

endpackage

// File: rtl/edgeSampler.sv
module edgeSampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  // rise seen between the synchronised sample and the one after it
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/phaseDatapath.sv
module phaseDatapath
  import phaseAlignPkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int CODE_INIT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlClkIn,
  input  logic              memClkIn,
  input  stepCmd_t          cmd,
  output edgePair_t         edges,
  output logic [CODE_W-1:0] phaseCode,
  output logic              stepUp,
  output logic              stepDown
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(CODE_INIT);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] riseVec;

  assign rawIn = {memClkIn, ctrlClkIn};

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : gSample
      edgeSampler #(.STAGES(SYNC_STAGES)) uSample (
        .clk  (clk),
        .rstN (rstN),
        .din  (rawIn[g]),
        .rise (riseVec[g])
      );
    end
  endgenerate

  assign edges = edgePair_t'{ctrlRise: riseVec[0], memRise: riseVec[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCode <= CODE_RST;
      stepUp    <= 1'b0;
      stepDown  <= 1'b0;
    end else begin
      stepUp   <= cmd.up;
      stepDown <= cmd.down;
      if (cmd.up && phaseCode != CODE_MAX)
        phaseCode <= phaseCode + 1'b1;
      else if (cmd.down && phaseCode != '0)
        phaseCode <= phaseCode - 1'b1;
    end
  end

  // R10
  step_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stepUp && stepDown));

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stepUp && !stepDown) |-> $stable(phaseCode));

  // R5
  code_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepUp && $past(phaseCode) == CODE_MAX) |-> phaseCode == CODE_MAX);

  // R5
  code_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepDown && $past(phaseCode) == '0) |-> phaseCode == '0);

  // R3
  up_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepUp |-> phaseCode >= $past(phaseCode));

endmodule

// File: rtl/pairControl.sv
module pairControl
  import phaseAlignPkg::*;
#(
  parameter int WINDOW     = 1,
  parameter int LOCK_COUNT = 4,
  parameter int IDLE_LIMIT = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      active,
  input  edgePair_t edges,
  output stepCmd_t  cmd,
  output logic      locked
);

  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam int LC_W   = $clog2(LOCK_COUNT + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_LIMIT);
  localparam logic [IDLE_W-1:0] WIN_V    = IDLE_W'(WINDOW);
  localparam logic [LC_W-1:0]   LC_MAX   = LC_W'(LOCK_COUNT);

  pairState_e        state, stateNext;
  logic [IDLE_W-1:0] sep, sepNext;
  logic [IDLE_W-1:0] ctrlIdle, memIdle;
  logic [LC_W-1:0]   goodCnt;
  logic [LC_W-1:0]   goodInc;
  logic              stalled;
  logic              decide;
  logic              inWin;
  stepCmd_t          cmdNext;

  // an input that rises this cycle is not counted as silent
  assign stalled = (ctrlIdle == IDLE_MAX && !edges.ctrlRise) ||
                   (memIdle  == IDLE_MAX && !edges.memRise);

  always_comb begin
    stateNext = state;
    sepNext   = sep;
    decide    = 1'b0;
    inWin     = 1'b0;
    cmdNext   = '0;
    if (!active || stalled) begin
      stateNext = PAIR_IDLE;
      sepNext   = '0;
    end else begin
      unique case (state)
        PAIR_IDLE: begin
          if (edges.ctrlRise && edges.memRise) begin
            decide = 1'b1;
            inWin  = 1'b1;
          end else if (edges.ctrlRise) begin
            stateNext = PAIR_WAIT_MEM;
            sepNext   = IDLE_W'(1);
          end else if (edges.memRise) begin
            stateNext = PAIR_WAIT_CTRL;
            sepNext   = IDLE_W'(1);
          end
        end
        PAIR_WAIT_MEM: begin
          if (edges.memRise) begin
            decide       = 1'b1;
            inWin        = (sep <= WIN_V);
            cmdNext.down = 1'b1;
            stateNext    = PAIR_IDLE;
            sepNext      = '0;
          end else if (edges.ctrlRise) begin
            sepNext = IDLE_W'(1);
          end else if (sep != IDLE_MAX) begin
            sepNext = sep + 1'b1;
          end
        end
        PAIR_WAIT_CTRL: begin
          if (edges.ctrlRise) begin
            decide     = 1'b1;
            inWin      = (sep <= WIN_V);
            cmdNext.up = 1'b1;
            stateNext  = PAIR_IDLE;
            sepNext    = '0;
          end else if (edges.memRise) begin
            sepNext = IDLE_W'(1);
          end else if (sep != IDLE_MAX) begin
            sepNext = sep + 1'b1;
          end
        end
        default: begin
          stateNext = PAIR_IDLE;
          sepNext   = '0;
        end
      endcase
    end
  end

  assign cmd     = cmdNext;
  assign goodInc = (goodCnt == LC_MAX) ? goodCnt : goodCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PAIR_IDLE;
      sep   <= '0;
    end else begin
      state <= stateNext;
      sep   <= sepNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlIdle <= '0;
      memIdle  <= '0;
    end else begin
      if (!active || edges.ctrlRise) ctrlIdle <= '0;
      else if (ctrlIdle != IDLE_MAX) ctrlIdle <= ctrlIdle + 1'b1;
      if (!active || edges.memRise)  memIdle  <= '0;
      else if (memIdle != IDLE_MAX)  memIdle  <= memIdle + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
      locked  <= 1'b0;
    end else if (!active || stalled) begin
      goodCnt <= '0;
      locked  <= 1'b0;
    end else if (decide) begin
      if (inWin) begin
        goodCnt <= goodInc;
        locked  <= (goodInc == LC_MAX);
      end else begin
        goodCnt <= '0;
        locked  <= 1'b0;
      end
    end
  end

  // R9
  inactive_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !locked);

  // R9
  inactive_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!cmd.up && !cmd.down));

  // R8
  stall_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    stalled |=> !locked);

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(decide));

endmodule

// File: rtl/phaseAligner.sv
module phaseAligner
  import phaseAlignPkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int CODE_INIT   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW      = 1,
  parameter int LOCK_COUNT  = 4,
  parameter int IDLE_LIMIT  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bypass,
  input  logic              ctrlClkIn,
  input  logic              memClkIn,
  output logic [CODE_W-1:0] phaseCode,
  output logic              stepUp,
  output logic              stepDown,
  output logic              locked
);

  edgePair_t edges;
  stepCmd_t  cmd;
  logic      active;

  assign active = enable & ~bypass;

  phaseDatapath #(
    .CODE_W      (CODE_W),
    .CODE_INIT   (CODE_INIT),
    .SYNC_STAGES (SYNC_STAGES)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlClkIn (ctrlClkIn),
    .memClkIn  (memClkIn),
    .cmd       (cmd),
    .edges     (edges),
    .phaseCode (phaseCode),
    .stepUp    (stepUp),
    .stepDown  (stepDown)
  );

  pairControl #(
    .WINDOW     (WINDOW),
    .LOCK_COUNT (LOCK_COUNT),
    .IDLE_LIMIT (IDLE_LIMIT)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .active (active),
    .edges  (edges),
    .cmd    (cmd),
    .locked (locked)
  );

endmodule

// File: tb/sim_phaseAligner.sv
`timescale 1ns/1ps
module sim_phaseAligner;

  localparam int PER   = 16;
  localparam int LOCKN = 4;
  localparam int WIN   = 1;
  localparam int CMAX  = 63;

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic       bypass;
  logic       ctrlClkIn;
  logic       memClkIn;
  logic [5:0] phaseCode;
  logic       stepUp;
  logic       stepDown;
  logic       locked;

  int checks = 0;
  int bad = 0;
  int cycle = 0;
  bit done = 0;
  int expCode = 32;
  int expCnt = 0;
  bit expLock = 0;

  typedef struct {
    bit    up;
    int    code;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  phaseAligner u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .bypass(bypass),
    .ctrlClkIn(ctrlClkIn), .memClkIn(memClkIn),
    .phaseCode(phaseCode), .stepUp(stepUp), .stepDown(stepDown), .locked(locked)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per observed step pulse
  always @(negedge clk) begin
    if (rstN && !done && (stepUp || stepDown)) begin
      if (expQ.size() == 0) begin
        check(0, "R9 unexpected step", int'(phaseCode), -1);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(stepUp == it.up && !(stepUp && stepDown), {it.tag, " direction"},
              int'(stepUp), int'(it.up));
        check(int'(phaseCode) == it.code, {it.tag, " code"}, int'(phaseCode), it.code);
      end
    end
  end

  always @(posedge clk) begin
    cycle++;
    if (cycle > 200000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 200000);
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  task automatic drivePair(input int lead, input bit ctrlFirst, input bit useC,
                           input bit useM, input int hiC, input int hiM);
    int cs;
    int ms;
    cs = ctrlFirst ? 0 : lead;
    ms = ctrlFirst ? lead : 0;
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      ctrlClkIn = useC && (c >= cs) && (c < cs + hiC);
      memClkIn  = useM && (c >= ms) && (c < ms + hiM);
    end
  endtask

  task automatic pairDuty(input int lead, input bit ctrlFirst, input string tag,
                          input int hiC, input int hiM);
    if (enable && !bypass) begin
      if (lead != 0) begin
        expItem_t it;
        if (ctrlFirst) expCode = (expCode > 0) ? expCode - 1 : 0;
        else           expCode = (expCode < CMAX) ? expCode + 1 : CMAX;
        it.up = !ctrlFirst;
        it.code = expCode;
        it.tag = tag;
        expQ.push_back(it);
      end
      if (lead <= WIN) begin
        if (expCnt < LOCKN) expCnt++;
        expLock = (expCnt >= LOCKN);
      end else begin
        expCnt = 0;
        expLock = 0;
      end
    end else begin
      expCnt = 0;
      expLock = 0;
    end
    drivePair(lead, ctrlFirst, 1'b1, 1'b1, hiC, hiM);
    check(locked == expLock, {tag, " lock"}, int'(locked), int'(expLock));
    check(expQ.size() == 0, {tag, " step due"}, expQ.size(), 0);
    check(int'(phaseCode) == expCode, {tag, " code held"}, int'(phaseCode), expCode);
  endtask

  task automatic pair(input int lead, input bit ctrlFirst, input string tag);
    pairDuty(lead, ctrlFirst, tag, 4, 11);
  endtask

  initial begin
    rstN = 0; enable = 1; bypass = 0; ctrlClkIn = 0; memClkIn = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(int'(phaseCode) == 32, "R1 code", int'(phaseCode), 32);
    check(!stepUp && !stepDown, "R1 steps", int'(stepUp) + int'(stepDown), 0);
    check(!locked, "R1 lock", int'(locked), 0);

    // R3 memory-side first, then controller-side first
    repeat (3) pair(3, 1'b0, "R3");
    repeat (2) pair(2, 1'b1, "R3");

    // R2 swapped duty cycles: falling edges move, rising edges decide
    pairDuty(2, 1'b0, "R2", 11, 4);
    pairDuty(2, 1'b1, "R2", 12, 3);
    pairDuty(4, 1'b1, "R2", 2, 9);

    // R4 and R6: zero-error pairs build lock on the fourth
    repeat (3) pair(0, 1'b0, "R4");
    check(!locked, "R6 not yet locked", int'(locked), 0);
    pair(0, 1'b0, "R6");
    check(locked, "R6 locked", int'(locked), 1);
    pair(1, 1'b0, "R6");
    // R7 one wide comparison drops lock
    pair(3, 1'b1, "R7");
    check(!locked, "R7 lock dropped", int'(locked), 0);

    // R8 both inputs grounded
    repeat (4) pair(0, 1'b0, "R8");
    repeat (100) @(negedge clk);
    expCnt = 0; expLock = 0;
    check(!locked, "R8 grounded lock", int'(locked), 0);
    check(int'(phaseCode) == expCode, "R8 grounded code", int'(phaseCode), expCode);
    pair(0, 1'b0, "R8");
    pair(1, 1'b0, "R8");

    // R8 only the memory-side input grounded
    for (int k = 0; k < 8; k++) drivePair(0, 1'b1, 1'b1, 1'b0, 4, 11);
    expCnt = 0; expLock = 0;
    check(!locked, "R8 one grounded lock", int'(locked), 0);
    check(int'(phaseCode) == expCode, "R8 one grounded code", int'(phaseCode), expCode);
    pair(0, 1'b0, "R8");
    pair(2, 1'b1, "R8");

    // R9 bypass and disable freeze the loop
    repeat (4) pair(0, 1'b0, "R6");
    check(locked, "R6 relocked", int'(locked), 1);
    bypass = 1;
    repeat (3) pair(3, 1'b0, "R9");
    bypass = 0;
    pair(3, 1'b0, "R9");
    enable = 0;
    repeat (2) pair(2, 1'b1, "R9");
    enable = 1;
    pair(2, 1'b1, "R9");

    // R5 saturation at both ends
    repeat (40) pair(2, 1'b0, "R5");
    check(int'(phaseCode) == CMAX, "R5 top", int'(phaseCode), CMAX);
    repeat (70) pair(2, 1'b1, "R5");
    check(int'(phaseCode) == 0, "R5 bottom", int'(phaseCode), 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule